// File: doc/BRIEF.md
# One-Time Fuse Array Controller

This block controls a one-time-programmable array of 32-bit fuse blocks over a plain register bus with address, write enable, read enable, write data and read data. Software opens a programming window by loading an unlock key and setting the power switches to the programming state. Each write to a fuse block then ORs the data into that block, because a blown fuse can never return to 0. Reads need the read-power enable and are refused with zero data otherwise.

Optional features are chosen through the control register. Redundant storage keeps a second copy of each block and flags copies that disagree. Auto-check reads the block back after programming and flags any requested bit that did not blow. A lock-mode write freezes a block for good. Every rejected or suspicious access raises one sticky error flag, and software clears flags by writing ones to a clear register. The fuse array is a behavioural model of flip-flops that is cleared by reset. One block carries a parameterised weak bit that never blows, so the verify path has a fault to find. Blocks 72 to 95 form the region that ordinary software uses, and the rest of the array sits below that region.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After synchronous active-low reset every register reads 0: control, error flags, key, firmware config and power switch.
- R2: A fuse-block write while the key register is not 0x0000_8810 changes no block and sets error bit 0.
- R3: Programming needs power-switch bit 2 (program enable) = 1, bit 0 (supply 1) = 1 and bit 1 (supply 2) = 0. Any other state rejects the write, changes no block and sets error bit 1.
- R4: An accepted program write ORs the data into block n at address 0x1000 + 4*n, so stored bits never go back to 0.
- R5: A fuse read with control bit 0 (read power) clear returns 0 and sets error bit 2.
- R6: With control bit 2 (double) set, a program write also ORs the data into a second copy. A read returns primary OR copy and sets error bit 3 when the two copies differ.
- R7: With control bit 1 (auto-check) set, after programming the block is read back in the current double mode. Error bit 4 is set if any requested bit is still 0. Bits in FAULT_MASK of block FAULT_BLK never blow in the primary copy.
- R8: An otherwise accepted write while control bit 4 (lock write) is set programs no data and locks the block. Later program writes to a locked block are rejected with error bit 5.
- R9: Blocks at or above NBLK (96) are out of range. Reads return 0, writes have no effect, and both set error bit 6.
- R10: Error flags are 14 sticky bits read at 0x24 with bits 31:14 reading 0. Writing ones to 0x28 clears the matching flags and leaves the others set.
- R11: Register map: control is 5 bits at 0x20, key is 32 bits at 0x2C, firmware config is 32 bits at 0x50 and the power switch is 3 bits at 0x54. Unused bits read 0. Read data appears on the clock edge that samples bus_re.
- R12: A rejected write raises exactly one flag, with checks taken in this order: range, then key, then power, then lock mode, then locked block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 13 | Byte address; bit 12 selects the fuse region |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_re | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench builds the block with its defaults: 96 blocks and a weak bit 8 in block 80. Block 80 therefore gives the auto-check a real failure in single mode. Block 80 also lets the double mode show a copy mismatch and recover the lost bit through the OR of both copies. Because 96 is not a power of two, block indices 96 to 1023 inside the decoded fuse window reach the range error path. Random traffic that mixes key, power, lock-mode and program writes lets the lock and priority rules meet each other.

// File: rtl/otp_pkg.sv
// Package: shared widths, register offsets, error flag positions and
// register field types of the fuse controller.
package otp_pkg;
    localparam int ADDR_W = 13;
    localparam int DW     = 32;
    localparam int ERR_W  = 14;

    localparam logic [ADDR_W-1:0] A_CTRL  = 13'h020;
    localparam logic [ADDR_W-1:0] A_ERR   = 13'h024;
    localparam logic [ADDR_W-1:0] A_ECLR  = 13'h028;
    localparam logic [ADDR_W-1:0] A_KEY   = 13'h02C;
    localparam logic [ADDR_W-1:0] A_FWCFG = 13'h050;
    localparam logic [ADDR_W-1:0] A_PWR   = 13'h054;

    localparam logic [DW-1:0] UNLOCK_KEY = 32'h0000_8810;

    // error flag bit positions
    localparam int E_KEY    = 0;
    localparam int E_PWR    = 1;
    localparam int E_NORDP  = 2;
    localparam int E_DUP    = 3;
    localparam int E_VERIFY = 4;
    localparam int E_LOCKED = 5;
    localparam int E_RANGE  = 6;

    typedef struct packed {
        logic lock_wr;   // bit 4
        logic margin_rd; // bit 3
        logic dbl;       // bit 2
        logic auto_chk;  // bit 1
        logic rd_pwr;    // bit 0
    } ctrl_t;

    typedef struct packed {
        logic prog_en;   // bit 2
        logic sup2;      // bit 1
        logic sup1;      // bit 0
    } pwr_t;
endpackage

// File: rtl/otp_cfg_regs.sv
// Module: configuration and status registers of the fuse controller.
// Holds control, power switch, key and firmware config, plus the sticky
// error flags with write-one-to-clear. Assumes reg_wr is asserted only
// for addresses outside the fuse window.
module otp_cfg_regs
    import otp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [ERR_W-1:0]  err_set,
    output ctrl_t             ctrl,
    output pwr_t              pwr,
    output logic              key_ok,
    output logic [DW-1:0]     reg_rval
);
    localparam int CTRL_W = $bits(ctrl_t);
    localparam int PWR_W  = $bits(pwr_t);

    logic [DW-1:0]    key_q;
    logic [DW-1:0]    fw_q;
    logic [ERR_W-1:0] err_q;
    logic [ERR_W-1:0] clr_mask;

    // writable configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= '0;
            pwr   <= '0;
            key_q <= '0;
            fw_q  <= '0;
        end else if (reg_wr) begin
            case (addr)
                A_CTRL:  ctrl  <= ctrl_t'(wdata[CTRL_W-1:0]);
                A_PWR:   pwr   <= pwr_t'(wdata[PWR_W-1:0]);
                A_KEY:   key_q <= wdata;
                A_FWCFG: fw_q  <= wdata;
                default: ;
            endcase
        end
    end

    // clear mask from a write to the clear register
    assign clr_mask = (reg_wr && addr == A_ECLR) ? wdata[ERR_W-1:0] : '0;

    // sticky error flags: new flags win over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= (err_q & ~clr_mask) | err_set;
    end

    assign key_ok = (key_q == UNLOCK_KEY);

    // register read mux
    always_comb begin
        reg_rval = '0;
        case (addr)
            A_CTRL:  reg_rval = DW'(ctrl);
            A_ERR:   reg_rval = DW'(err_q);
            A_KEY:   reg_rval = key_q;
            A_FWCFG: reg_rval = fw_q;
            A_PWR:   reg_rval = DW'(pwr);
            default: reg_rval = '0;
        endcase
    end

    // R10: without a clear write, no set flag drops
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && addr == A_ECLR) |=> ((err_q & $past(err_q)) == $past(err_q)));
endmodule

// File: rtl/otp_fuse_array.sv
// Module: behavioural fuse array. Each block keeps a primary word, a
// redundant copy and a lock bit; programming can only set bits. Block
// FAULT_BLK has FAULT_MASK bits that never blow in the primary copy.
// Assumes prog and lock_set are only raised for an in-range idx.
module otp_fuse_array #(
    parameter int          NBLK       = 96,
    parameter int          DW         = 32,
    parameter int          FAULT_BLK  = 80,
    parameter logic [31:0] FAULT_MASK = 32'h0000_0100,
    localparam int         IW         = $clog2(NBLK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] idx,
    input  logic          prog,
    input  logic          lock_set,
    input  logic          dbl,
    input  logic [DW-1:0] pdata,
    output logic [DW-1:0] rd_main,
    output logic [DW-1:0] rd_copy,
    output logic          locked,
    output logic [DW-1:0] post_rd
);
    logic [DW-1:0] main_w [NBLK];
    logic [DW-1:0] copy_w [NBLK];
    logic [DW-1:0] weak_w [NBLK];
    logic [NBLK-1:0] lock_w;
    logic [DW-1:0] weak_sel;

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        localparam logic [DW-1:0] WEAK = (b == FAULT_BLK) ? DW'(FAULT_MASK) : '0;
        logic [DW-1:0] main_r;
        logic [DW-1:0] copy_r;
        logic          lock_r;
        logic          hit;

        assign hit = (idx == IW'(b));

        // program or lock this block
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                main_r <= '0;
                copy_r <= '0;
                lock_r <= 1'b0;
            end else if (hit && prog) begin
                main_r <= main_r | (pdata & ~WEAK);
                if (dbl) copy_r <= copy_r | pdata;
            end else if (hit && lock_set) begin
                lock_r <= 1'b1;
            end
        end

        assign main_w[b] = main_r;
        assign copy_w[b] = copy_r;
        assign weak_w[b] = WEAK;
        assign lock_w[b] = lock_r;

        // R4: a blown bit stays blown
        p_or_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ((main_r & $past(main_r)) == $past(main_r)) &&
            ((copy_r & $past(copy_r)) == $past(copy_r)));
        // R8: a locked block never changes again
        p_lock_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
            lock_r |=> lock_r && $stable(main_r) && $stable(copy_r));
    end

    // read port for the addressed block
    always_comb begin
        rd_main  = '0;
        rd_copy  = '0;
        weak_sel = '0;
        locked   = 1'b0;
        for (int b = 0; b < NBLK; b++) begin
            if (idx == IW'(b)) begin
                rd_main  = main_w[b];
                rd_copy  = copy_w[b];
                weak_sel = weak_w[b];
                locked   = lock_w[b];
            end
        end
    end

    // value the block reads as once this cycle's programming has landed
    always_comb begin
        post_rd = rd_main | (pdata & ~weak_sel);
        if (dbl) post_rd = post_rd | rd_copy | pdata;
    end
endmodule

// File: rtl/otp_prog_gate.sv
// Module: access gate. Decides per fuse access whether it programs,
// locks, reads or is refused, and which single error flag it raises.
// Assumes the array feeds back the addressed block in the same cycle.
module otp_prog_gate
    import otp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fuse_wr,
    input  logic             fuse_rd,
    input  logic             in_range,
    input  logic             key_ok,
    input  logic             lock_wr,
    input  logic             auto_chk,
    input  logic             dbl,
    input  logic             rd_pwr,
    input  pwr_t             pwr,
    input  logic             locked,
    input  logic [DW-1:0]    rd_main,
    input  logic [DW-1:0]    rd_copy,
    input  logic [DW-1:0]    post_rd,
    input  logic [DW-1:0]    wdata,
    output logic             do_prog,
    output logic             do_lock,
    output logic [ERR_W-1:0] err_set,
    output logic [DW-1:0]    rd_val
);
    logic pwr_ok;

    assign pwr_ok = pwr.prog_en && pwr.sup1 && !pwr.sup2;

    // priority chain for writes, gating for reads
    always_comb begin
        do_prog = 1'b0;
        do_lock = 1'b0;
        err_set = '0;
        rd_val  = '0;
        if (fuse_wr) begin
            if (!in_range)     err_set[E_RANGE]  = 1'b1;
            else if (!key_ok)  err_set[E_KEY]    = 1'b1;
            else if (!pwr_ok)  err_set[E_PWR]    = 1'b1;
            else if (lock_wr)  do_lock           = 1'b1;
            else if (locked)   err_set[E_LOCKED] = 1'b1;
            else begin
                do_prog = 1'b1;
                if (auto_chk && ((post_rd & wdata) != wdata))
                    err_set[E_VERIFY] = 1'b1;
            end
        end else if (fuse_rd) begin
            if (!in_range)     err_set[E_RANGE] = 1'b1;
            else if (!rd_pwr)  err_set[E_NORDP] = 1'b1;
            else if (dbl) begin
                rd_val = rd_main | rd_copy;
                if (rd_main != rd_copy) err_set[E_DUP] = 1'b1;
            end else begin
                rd_val = rd_main;
            end
        end
    end

    // R2: a change to the array needs the key and an in-range block
    p_gate_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (do_prog || do_lock) |-> (key_ok && in_range));
    // R3: a change to the array needs the programming power state
    p_gate_pwr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (do_prog || do_lock) |-> (pwr == 3'b101));
    // R8: a locked block is never programmed
    p_no_prog_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        do_prog |-> !locked);
    // R12: one flag at most per access
    p_one_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(err_set));
endmodule

// File: rtl/otp_fuse_ctrl.sv
// Module: top of the fuse controller. Decodes the register bus into the
// register file and the fuse window (address bit 12), runs the access
// gate and registers read data. Assumes one access per cycle at most.
module otp_fuse_ctrl
    import otp_pkg::*;
#(
    parameter int          NBLK       = 96,
    parameter int          FAULT_BLK  = 80,
    parameter logic [31:0] FAULT_MASK = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata
);
    localparam int IW = $clog2(NBLK);
    localparam int FW = ADDR_W - 3;

    logic             fuse_hit;
    logic [FW-1:0]    fidx;
    logic             in_range;
    ctrl_t            ctrl;
    pwr_t             pwr;
    logic             key_ok;
    logic [DW-1:0]    reg_rval;
    logic [ERR_W-1:0] err_set;
    logic             do_prog;
    logic             do_lock;
    logic [DW-1:0]    rd_main;
    logic [DW-1:0]    rd_copy;
    logic [DW-1:0]    post_rd;
    logic             locked;
    logic [DW-1:0]    rd_val;

    assign fuse_hit = bus_addr[ADDR_W-1];
    assign fidx     = bus_addr[ADDR_W-2:2];
    assign in_range = (fidx < FW'(NBLK));

    otp_cfg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (bus_we && !fuse_hit),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .err_set  (err_set),
        .ctrl     (ctrl),
        .pwr      (pwr),
        .key_ok   (key_ok),
        .reg_rval (reg_rval)
    );

    otp_fuse_array #(
        .NBLK       (NBLK),
        .DW         (DW),
        .FAULT_BLK  (FAULT_BLK),
        .FAULT_MASK (FAULT_MASK)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (fidx[IW-1:0]),
        .prog     (do_prog),
        .lock_set (do_lock),
        .dbl      (ctrl.dbl),
        .pdata    (bus_wdata),
        .rd_main  (rd_main),
        .rd_copy  (rd_copy),
        .locked   (locked),
        .post_rd  (post_rd)
    );

    otp_prog_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .fuse_wr  (bus_we && fuse_hit),
        .fuse_rd  (bus_re && fuse_hit),
        .in_range (in_range),
        .key_ok   (key_ok),
        .lock_wr  (ctrl.lock_wr),
        .auto_chk (ctrl.auto_chk),
        .dbl      (ctrl.dbl),
        .rd_pwr   (ctrl.rd_pwr),
        .pwr      (pwr),
        .locked   (locked),
        .rd_main  (rd_main),
        .rd_copy  (rd_copy),
        .post_rd  (post_rd),
        .wdata    (bus_wdata),
        .do_prog  (do_prog),
        .do_lock  (do_lock),
        .err_set  (err_set),
        .rd_val   (rd_val)
    );

    // registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= fuse_hit ? rd_val : reg_rval;
    end

    // R5: an unpowered fuse read returns zero
    p_rd_unpowered_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !bus_we && fuse_hit && !ctrl.rd_pwr) |=> (bus_rdata == '0));
    // R9: an out-of-range fuse read returns zero
    p_rd_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !bus_we && fuse_hit && !in_range) |=> (bus_rdata == '0));
endmodule

// File: tb/otp_fuse_ctrl_tb.sv
module otp_fuse_ctrl_tb;
    localparam int          NB    = 96;
    localparam int          WBLK  = 80;
    localparam logic [31:0] WMASK = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] addr = '0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // reference model state, built from the requirements
    logic [31:0] m_main [NB];
    logic [31:0] m_copy [NB];
    bit          m_lock [NB];
    logic [13:0] m_err;
    logic [4:0]  m_ctrl;
    logic [2:0]  m_pwr;
    logic [31:0] m_key;
    logic [31:0] m_fw;

    always #4 clk = ~clk;

    otp_fuse_ctrl #(.NBLK(NB), .FAULT_BLK(WBLK), .FAULT_MASK(WMASK)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_re(re),
        .bus_wdata(wdata), .bus_rdata(rdata)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [12:0] blk(input int n);
        return 13'(32'h1000 + 4 * n);
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic model_wr(input logic [12:0] a, input logic [31:0] d);
        int i;
        logic [31:0] post;
        if (a[12]) begin
            i = int'(a[11:2]);
            if (i >= NB)                 m_err[6] = 1'b1;
            else if (m_key != 32'h8810)  m_err[0] = 1'b1;
            else if (m_pwr != 3'b101)    m_err[1] = 1'b1;
            else if (m_ctrl[4])          m_lock[i] = 1'b1;
            else if (m_lock[i])          m_err[5] = 1'b1;
            else begin
                m_main[i] = m_main[i] | (d & ((i == WBLK) ? ~WMASK : 32'hFFFF_FFFF));
                if (m_ctrl[2]) m_copy[i] = m_copy[i] | d;
                post = m_ctrl[2] ? (m_main[i] | m_copy[i]) : m_main[i];
                if (m_ctrl[1] && ((post & d) != d)) m_err[4] = 1'b1;
            end
        end else begin
            case (a)
                13'h020: m_ctrl = d[4:0];
                13'h028: m_err  = m_err & ~d[13:0];
                13'h02C: m_key  = d;
                13'h050: m_fw   = d;
                13'h054: m_pwr  = d[2:0];
                default: ;
            endcase
        end
    endtask

    task automatic model_rd(input logic [12:0] a, output logic [31:0] e);
        int i;
        e = '0;
        if (a[12]) begin
            i = int'(a[11:2]);
            if (i >= NB)         m_err[6] = 1'b1;
            else if (!m_ctrl[0]) m_err[2] = 1'b1;
            else if (m_ctrl[2]) begin
                e = m_main[i] | m_copy[i];
                if (m_main[i] != m_copy[i]) m_err[3] = 1'b1;
            end else e = m_main[i];
        end else begin
            case (a)
                13'h020: e = {27'd0, m_ctrl};
                13'h024: e = {18'd0, m_err};
                13'h02C: e = m_key;
                13'h050: e = m_fw;
                13'h054: e = {29'd0, m_pwr};
                default: e = '0;
            endcase
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        model_wr(a, d);
    endtask

    task automatic rd_raw(input logic [12:0] a, output logic [31:0] got, output logic [31:0] e);
        @(negedge clk);
        addr = a; re = 1'b1;
        @(negedge clk);
        re = 1'b0;
        got = rdata;
        model_rd(a, e);
    endtask

    // compare against a literal from the requirement
    task automatic rd_lit(input logic [12:0] a, input logic [31:0] exp, input string req);
        logic [31:0] got, e;
        rd_raw(a, got, e);
        check(req, got, exp);
    endtask

    // compare against the reference model
    task automatic rd_mod(input logic [12:0] a, input string req);
        logic [31:0] got, e;
        rd_raw(a, got, e);
        check(req, got, e);
    endtask

    initial begin
        void'($urandom(32'd20240607));
        for (int i = 0; i < NB; i++) begin
            m_main[i] = '0; m_copy[i] = '0; m_lock[i] = 1'b0;
        end
        m_err = '0; m_ctrl = '0; m_pwr = '0; m_key = '0; m_fw = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_lit(13'h020, 32'h0, "R1 ctrl");
        rd_lit(13'h024, 32'h0, "R1 err");
        rd_lit(13'h02C, 32'h0, "R1 key");
        rd_lit(13'h050, 32'h0, "R1 fwcfg");
        rd_lit(13'h054, 32'h0, "R1 pwr");

        // R11: register map and field widths
        wr(13'h020, 32'hFFFF_FFFF); rd_lit(13'h020, 32'h1F, "R11 ctrl width");
        wr(13'h054, 32'hFFFF_FFFF); rd_lit(13'h054, 32'h7, "R11 pwr width");
        wr(13'h02C, 32'h1234_5678); rd_lit(13'h02C, 32'h1234_5678, "R11 key");
        wr(13'h050, 32'hCAFE_F00D); rd_lit(13'h050, 32'hCAFE_F00D, "R11 fwcfg");
        wr(13'h024, 32'hFFFF_FFFF); rd_lit(13'h024, 32'h0, "R11 err read-only");
        wr(13'h020, 32'h0); wr(13'h054, 32'h0);

        // R5: unpowered read
        rd_lit(blk(72), 32'h0, "R5 unpowered data");
        rd_lit(13'h024, 32'h4, "R5 flag");
        wr(13'h028, 32'h3FFF); rd_lit(13'h024, 32'h0, "R10 clear all");

        // R2: wrong key
        wr(13'h054, 32'h5);
        wr(blk(72), 32'h0000_000F);
        rd_lit(13'h024, 32'h1, "R2 flag");
        wr(13'h020, 32'h1);
        rd_lit(blk(72), 32'h0, "R2 block unchanged");
        wr(13'h028, 32'h3FFF);

        // R3: power state
        wr(13'h02C, 32'h0000_8810);
        wr(13'h054, 32'h7);
        wr(blk(72), 32'h0000_000F);
        wr(13'h054, 32'h3);
        wr(blk(72), 32'h0000_000F);
        rd_lit(13'h024, 32'h2, "R3 flag");
        rd_lit(blk(72), 32'h0, "R3 block unchanged");
        wr(13'h028, 32'h1); rd_lit(13'h024, 32'h2, "R10 partial clear keeps");
        wr(13'h028, 32'h2); rd_lit(13'h024, 32'h0, "R10 partial clear drops");

        // R4: OR-only programming
        wr(13'h054, 32'h5);
        wr(blk(72), 32'h0000_00F0);
        wr(blk(72), 32'h0000_0F0F);
        rd_lit(blk(72), 32'h0000_0FFF, "R4 or of writes");
        wr(blk(72), 32'h0);
        rd_lit(blk(72), 32'h0000_0FFF, "R4 zero write keeps bits");
        rd_lit(13'h024, 32'h0, "R4 no flag");

        // R6: redundant copies
        wr(13'h020, 32'h5);
        rd_lit(blk(72), 32'h0000_0FFF, "R6 or of copies");
        rd_lit(13'h024, 32'h8, "R6 mismatch flag");
        wr(13'h028, 32'h3FFF);
        wr(blk(73), 32'hA5A5_0000);
        rd_lit(blk(73), 32'hA5A5_0000, "R6 both copies");
        rd_lit(13'h024, 32'h0, "R6 copies agree");
        wr(blk(WBLK), 32'h0000_0300);
        rd_lit(blk(WBLK), 32'h0000_0300, "R6 copy recovers weak bit");
        rd_lit(13'h024, 32'h8, "R6 weak bit mismatch");
        wr(13'h020, 32'h1);
        rd_lit(blk(WBLK), 32'h0000_0200, "R6 primary alone");
        wr(13'h028, 32'h3FFF);

        // R7: auto-check
        wr(13'h020, 32'h3);
        wr(blk(WBLK), 32'h0000_0100);
        rd_lit(13'h024, 32'h10, "R7 verify fail");
        wr(13'h028, 32'h3FFF);
        wr(blk(81), 32'h0000_0001);
        rd_lit(13'h024, 32'h0, "R7 verify pass");
        wr(13'h020, 32'h7);
        wr(blk(WBLK), 32'h0000_0100);
        rd_lit(13'h024, 32'h8 & 32'h0, "R7 double read-back passes");

        // R8: lock mode
        wr(13'h020, 32'h11);
        wr(blk(74), 32'hFFFF_FFFF);
        wr(13'h020, 32'h1);
        rd_lit(blk(74), 32'h0, "R8 lock writes no data");
        wr(blk(74), 32'h0000_0001);
        rd_lit(13'h024, 32'h20, "R8 locked flag");
        rd_lit(blk(74), 32'h0, "R8 locked block unchanged");
        wr(13'h028, 32'h3FFF);

        // R9: range
        wr(blk(96), 32'hFFFF_FFFF);
        rd_lit(13'h024, 32'h40, "R9 write flag");
        wr(13'h028, 32'h3FFF);
        rd_lit(blk(100), 32'h0, "R9 read data");
        rd_lit(13'h024, 32'h40, "R9 read flag");
        rd_lit(13'h1FFC, 32'h0, "R9 top of window");
        rd_lit(blk(0), 32'h0, "R9 alias block 0 untouched");
        wr(13'h028, 32'h3FFF);

        // R12: priority, one flag
        wr(13'h02C, 32'h0); wr(13'h054, 32'h0);
        wr(blk(97), 32'h1);
        rd_lit(13'h024, 32'h40, "R12 range first");
        wr(13'h028, 32'h3FFF);
        wr(blk(75), 32'h1);
        rd_lit(13'h024, 32'h1, "R12 key before power");
        wr(13'h028, 32'h3FFF);
        wr(13'h02C, 32'h0000_8810); wr(13'h020, 32'h10);
        wr(blk(75), 32'h1);
        rd_lit(13'h024, 32'h2, "R12 power before lock mode");
        wr(13'h028, 32'h3FFF);
        wr(13'h054, 32'h5); wr(13'h020, 32'h1);
        wr(blk(75), 32'h3);
        rd_lit(blk(75), 32'h3, "R12 refused lock left block open");

        // random traffic against the model
        for (int k = 0; k < 800; k++) begin
            int op;
            logic [31:0] d;
            op = int'($urandom % 16);
            d = $urandom & $urandom;
            case (op)
                0: begin
                    d = $urandom;
                    if ($urandom % 6 != 0) d[4] = 1'b0;
                    wr(13'h020, d);
                end
                1: wr(13'h02C, ($urandom % 4 != 0) ? 32'h0000_8810 : $urandom);
                2: wr(13'h054, ($urandom % 3 != 0) ? 32'h5 : $urandom);
                3: wr(13'h028, $urandom);
                4: rd_mod(13'h024, "R10 random flags");
                5, 6, 7, 8, 9: wr(blk(64 + int'($urandom % 38)), d);
                default: rd_mod(blk(64 + int'($urandom % 38)), "R4 random read");
            endcase
        end
        rd_mod(13'h024, "R12 final flags");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule